// File: doc/BRIEF.md
# Serial Register Front End for a 256-Step Digital Potentiometer

This block is the control side of a digitally set potentiometer. It sits behind a four-wire serial slave port (chip select, serial clock, data in, data out), holds the tap code that picks one of 256 wiper positions, and keeps a power-on value for that code along with fourteen bytes of user storage. The storage that would be non-volatile on silicon is modelled here as ordinary flip-flops that only the power-on reset clears. A separate warm reset copies the power-on value back into the wiper.

Each command is a 16-bit word: an instruction byte with an opcode and an address, then a data byte. Commands take effect only when chip select returns high. Several devices can share one select line by wiring each data output to the next data input. The host then clocks one word per device, and the word for the device farthest down the chain goes first. A read takes two select windows. The first window queues the request. In the second window the block shifts out an echo of the instruction byte and then the register value, while the host sends a no-operation word. The serial pins are sampled with the system clock, so the serial clock must run well below it.

Top module: `dpot_spi_regs`

## Requirements
- R1: On power-on reset (`por_n` low) the wiper code and the initial-value register both become `IVR_INIT` (default 0x80), all general-purpose registers become 0x00, and the shutdown flag becomes 0. On warm reset (`rst_n` low, `por_n` high) the wiper takes the current initial-value register contents and the shutdown flag clears. The initial-value and general-purpose registers keep their contents.
- R2: Words are received MSB first and sampled on the rising serial clock edge. Instruction byte bits 7:4 carry the opcode: 0x0 no-op, 0x1 read, 0x2 write, 0x3 shutdown control. Bits 3:0 carry the address: 0 wiper, 1 initial value, 2 to 15 general purpose. Any other opcode changes nothing.
- R3: A write changes no register or output before chip select rises. It is applied on that rising edge.
- R4: A write to address 0 sets the wiper output. A write to address 1 changes only the initial-value register and leaves the wiper as it was.
- R5: Each general-purpose address stores its own byte, and a later write to a different address leaves it unchanged.
- R6: After a window whose executed word is a read of address A, the next window shifts out {0x1, A} and then the byte held at A, MSB first, from its first serial clock.
- R7: A window whose bit count is zero or not a multiple of 16 executes nothing.
- R8: Data out repeats data in 16 serial clocks later, and the word executed is the last 16 bits received before chip select rises.
- R9: `sdo_oe` is low whenever chip select has been high for more than a few system clocks. While it is high, `sdo` changes only after a falling serial clock edge or at the start of a window.
- R10: A shutdown-control word sets the shutdown flag to data bit 0 and leaves the wiper unchanged.
- R11: A window that does not follow a read shifts out zeros for its first 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all registers |
| rst_n | input | 1 | Synchronous warm reset, active low; reloads the wiper |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, held low when not driven |
| sdo_oe | output | 1 | Output enable for `sdo`; the pad is high impedance when low |
| wiper | output | 8 | Tap code driving the resistor array |
| shutdown | output | 1 | Shutdown request to the analog array |

## Verification
A corrupted shift register shows up on the data output within 16 serial clocks, because every bit returned in a window is either the echo/data pair or the input delayed by exactly one word. A bad bit counter or decode shows up at the next chip-select rise: the wiper or shutdown output moves when it should hold, or holds when it should move. A lost or stuck pending read shows up in the very next window as a wrong echo byte or as nonzero leading bits.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int OP_W    = DATA_W - ADDR_W;
    localparam int FRAME_W = 2 * DATA_W;
    localparam int N_REGS  = 1 << ADDR_W;

    localparam int ADDR_WIPER = 0;
    localparam int ADDR_INIT  = 1;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'h0,
        OP_READ = 4'h1,
        OP_WRITE = 4'h2,
        OP_SHDN = 4'h3
    } op_e;
endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], din[i]};
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sh_q <= {(STAGES+1){RST_VAL[i]}};
            else        sh_q <= sh_d;
        end

        assign dout[i] = sh_q[STAGES-1];
        assign rise[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
        assign fall[i] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/dpot_frame_shifter.sv
module dpot_frame_shifter #(
    parameter int FRAME_W = dpot_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               sel_low,
    input  logic               sel_fall,
    input  logic               sel_rise,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               din,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    output logic               dout,
    output logic [FRAME_W-1:0] word,
    output logic               word_ok
);
    localparam int CNT_W = $clog2(FRAME_W);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic               hold;
        logic [CNT_W-1:0]   cnt;
        logic               any;
        logic               ok;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ok = 1'b0;
        if (sel_fall) begin
            st_d.shreg = load_en ? load_word : '0;
            st_d.cnt   = '0;
            st_d.any   = 1'b0;
        end else if (sel_low) begin
            if (sck_rise) st_d.hold = din;
            if (sck_fall) begin
                st_d.shreg = {st_q.shreg[FRAME_W-2:0], st_q.hold};
                st_d.cnt   = (st_q.cnt == CNT_W'(FRAME_W-1)) ? '0 : st_q.cnt + 1'b1;
                st_d.any   = 1'b1;
            end
        end
        if (sel_rise) st_d.ok = st_q.any && (st_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.shreg[FRAME_W-1];
    assign word    = st_q.shreg;
    assign word_ok = st_q.ok;
endmodule

// File: rtl/dpot_reg_file.sv
module dpot_reg_file
    import dpot_pkg::*;
#(
    parameter logic [DATA_W-1:0] IVR_INIT = 8'h80
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               exec,
    input  logic [FRAME_W-1:0] cmd,
    input  logic               sel_fall,
    output logic [DATA_W-1:0]  wiper,
    output logic [DATA_W-1:0]  ivr,
    output logic               shdn,
    output logic               load_en,
    output logic [FRAME_W-1:0] load_word
);
    typedef struct packed {
        logic [N_REGS-1:0][DATA_W-1:0] regs;
        logic                          shdn;
        logic                          pend;
        logic [ADDR_W-1:0]             pend_addr;
    } rf_t;

    rf_t rf_d, rf_q;

    logic [OP_W-1:0]   cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;

    assign cmd_op   = cmd[FRAME_W-1 -: OP_W];
    assign cmd_addr = cmd[DATA_W +: ADDR_W];
    assign cmd_data = cmd[DATA_W-1:0];

    always_comb begin
        rf_d = rf_q;
        if (sel_fall) rf_d.pend = 1'b0;
        if (exec) begin
            rf_d.pend = 1'b0;
            case (cmd_op)
                OP_READ: begin
                    rf_d.pend      = 1'b1;
                    rf_d.pend_addr = cmd_addr;
                end
                OP_WRITE: rf_d.regs[cmd_addr] = cmd_data;
                OP_SHDN:  rf_d.shdn = cmd_data[0];
                default:  ;
            endcase
        end
        if (!rst_n) begin
            rf_d.regs[ADDR_WIPER] = rf_q.regs[ADDR_INIT];
            rf_d.shdn             = 1'b0;
            rf_d.pend             = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rf_q                  <= '0;
            rf_q.regs[ADDR_WIPER] <= IVR_INIT;
            rf_q.regs[ADDR_INIT]  <= IVR_INIT;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign wiper     = rf_q.regs[ADDR_WIPER];
    assign ivr       = rf_q.regs[ADDR_INIT];
    assign shdn      = rf_q.shdn;
    assign load_en   = rf_q.pend;
    assign load_word = {OP_READ, rf_q.pend_addr, rf_q.regs[rf_q.pend_addr]};
endmodule

// File: rtl/dpot_spi_regs.sv
module dpot_spi_regs
    import dpot_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] IVR_INIT    = 8'h80
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [DATA_W-1:0] wiper,
    output logic              shutdown
);
    localparam int PIN_CS  = 2;
    localparam int PIN_SCK = 1;
    localparam int PIN_SDI = 0;

    logic [2:0] pin_lvl, pin_rise, pin_fall;

    dpot_pin_sync #(
        .N       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   ({cs_n, sck, sdi}),
        .dout  (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    logic               sel_low, sel_fall, sel_rise;
    logic               sck_rise, sck_fall;
    logic               shift_out;
    logic [FRAME_W-1:0] word;
    logic               exec_stb;
    logic               load_en;
    logic [FRAME_W-1:0] load_word;
    logic [DATA_W-1:0]  ivr_val;

    assign sel_low  = ~pin_lvl[PIN_CS];
    assign sel_fall = pin_fall[PIN_CS];
    assign sel_rise = pin_rise[PIN_CS];
    assign sck_rise = pin_rise[PIN_SCK];
    assign sck_fall = pin_fall[PIN_SCK];

    dpot_frame_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk       (clk),
        .por_n     (por_n),
        .sel_low   (sel_low),
        .sel_fall  (sel_fall),
        .sel_rise  (sel_rise),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .din       (pin_lvl[PIN_SDI]),
        .load_en   (load_en),
        .load_word (load_word),
        .dout      (shift_out),
        .word      (word),
        .word_ok   (exec_stb)
    );

    dpot_reg_file #(
        .IVR_INIT (IVR_INIT)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .exec      (exec_stb),
        .cmd       (word),
        .sel_fall  (sel_fall),
        .wiper     (wiper),
        .ivr       (ivr_val),
        .shdn      (shutdown),
        .load_en   (load_en),
        .load_word (load_word)
    );

    assign sdo_oe = sel_low;
    assign sdo    = shift_out & sel_low;
endmodule

// File: rtl/dpot_spi_regs_checker.sv
module dpot_spi_regs_checker (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo,
    input logic       sdo_oe,
    input logic [7:0] wiper,
    input logic       shutdown,
    input logic       exec,
    input logic       sck_fall,
    input logic       sel_fall,
    input logic [7:0] ivr
);
    logic [2:0] since_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                since_q <= '0;
        else if (since_q != 3'd7)  since_q <= since_q + 3'd1;
    end

    // R9: output driver released once select has stayed high
    a_r9_sdo_released: assert property (@(posedge clk) disable iff (!por_n)
        (since_q >= 3'd4 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> !sdo_oe);

    // R9: data out moves only after a serial clock fall or window start
    a_r9_sdo_on_fall: assert property (@(posedge clk) disable iff (!por_n)
        (since_q >= 3'd1 && sdo_oe && $past(sdo_oe) && sdo != $past(sdo))
        |-> ($past(sck_fall) || $past(sel_fall)));

    // R3: wiper moves only on an executed word or a warm reset
    a_r3_wiper_on_exec: assert property (@(posedge clk) disable iff (!por_n)
        (since_q >= 3'd1 && wiper != $past(wiper)) |-> $past(exec || !rst_n));

    // R10: shutdown flag moves only on an executed word or a warm reset
    a_r10_shdn_on_exec: assert property (@(posedge clk) disable iff (!por_n)
        (since_q >= 3'd1 && shutdown != $past(shutdown)) |-> $past(exec || !rst_n));

    // R1: warm reset reloads the wiper from the initial-value register
    a_r1_warm_reload: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (wiper == $past(ivr) && !shutdown));
endmodule

bind dpot_spi_regs dpot_spi_regs_checker u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .wiper    (wiper),
    .shutdown (shutdown),
    .exec     (exec_stb),
    .sck_fall (sck_fall),
    .sel_fall (sel_fall),
    .ivr      (ivr_val)
);

// File: tb/dpot_spi_regs_bench.sv
module dpot_spi_regs_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, shutdown;
    logic [7:0] wiper;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dpot_spi_regs u_dpot_spi_regs (
        .clk      (clk),
        .por_n    (por_n),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .wiper    (wiper),
        .shutdown (shutdown)
    );

    // address (4 bits) and data (8 bits) written then read back
    localparam logic [11:0] VEC [8] = '{
        {4'd0,  8'h3C}, {4'd2,  8'hA5}, {4'd15, 8'h5A}, {4'd7,  8'hFF},
        {4'd1,  8'h11}, {4'd9,  8'h00}, {4'd0,  8'hC3}, {4'd14, 8'h81}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic sel_begin();
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic sel_end();
        @(negedge clk) cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n, output logic [31:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got = {got[30:0], sdo};
            sdi = bits[n-1-i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic frame(input logic [31:0] bits, input int n, output logic [31:0] got);
        sel_begin();
        shift_bits(bits, n, got);
        sel_end();
    endtask

    task automatic wr(input logic [3:0] op, input logic [3:0] a, input logic [7:0] d);
        logic [31:0] g;
        frame({16'h0, op, a, d}, 16, g);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d, input string tag);
        logic [31:0] g;
        frame({16'h0, 4'h1, a, 8'h00}, 16, g);
        frame(32'h0, 16, g);
        check({tag, " echo"}, {24'h0, g[15:8]}, {24'h0, 4'h1, a});
        d = g[7:0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [31:0] g;
        logic [7:0]  keep;

        repeat (4) @(negedge clk);
        por_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1 reset state, R9 driver off while idle
        check("R1 wiper after por", {24'h0, wiper}, 32'h80);
        check("R1 shutdown after por", {31'h0, shutdown}, 32'h0);
        check("R9 sdo_oe idle", {31'h0, sdo_oe}, 32'h0);
        rd(4'd1, d, "R1 ivr");
        check("R1 ivr after por", {24'h0, d}, 32'h80);
        rd(4'd5, d, "R1 gp");
        check("R1 gp after por", {24'h0, d}, 32'h0);

        // R4 R5 R6: table of write/readback vectors
        foreach (VEC[i]) begin
            wr(4'h2, VEC[i][11:8], VEC[i][7:0]);
            rd(VEC[i][11:8], d, "R6 table");
            check("R5 R6 table readback", {24'h0, d}, {24'h0, VEC[i][7:0]});
            if (VEC[i][11:8] == 4'd0)
                check("R4 wiper from table", {24'h0, wiper}, {24'h0, VEC[i][7:0]});
        end
        rd(4'd2, d, "R5 keep");
        check("R5 gp2 kept", {24'h0, d}, 32'hA5);
        rd(4'd15, d, "R5 keep");
        check("R5 gp15 kept", {24'h0, d}, 32'h5A);

        // R4: write to the initial-value register leaves the wiper
        keep = wiper;
        wr(4'h2, 4'd1, 8'h77);
        check("R4 wiper untouched by ivr write", {24'h0, wiper}, {24'h0, keep});

        // R3: nothing happens before select rises
        sel_begin();
        shift_bits({16'h0, 4'h2, 4'd0, 8'h42}, 16, g);
        check("R9 sdo_oe in window", {31'h0, sdo_oe}, 32'h1);
        repeat (10) @(negedge clk);
        check("R3 wiper before select rise", {24'h0, wiper}, {24'h0, keep});
        sel_end();
        check("R3 wiper after select rise", {24'h0, wiper}, 32'h42);
        check("R9 sdo_oe after window", {31'h0, sdo_oe}, 32'h0);

        // R10: shutdown control
        wr(4'h3, 4'd0, 8'h01);
        check("R10 shutdown set", {31'h0, shutdown}, 32'h1);
        check("R10 wiper kept", {24'h0, wiper}, 32'h42);
        wr(4'h3, 4'd0, 8'h00);
        check("R10 shutdown clear", {31'h0, shutdown}, 32'h0);
        wr(4'h3, 4'd0, 8'h01);

        // R1: warm reset reloads wiper from ivr, keeps storage
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 warm wiper reload", {24'h0, wiper}, 32'h77);
        check("R1 warm shutdown clear", {31'h0, shutdown}, 32'h0);
        rd(4'd1, d, "R1 warm");
        check("R1 ivr kept", {24'h0, d}, 32'h77);
        rd(4'd14, d, "R1 warm");
        check("R1 gp kept", {24'h0, d}, 32'h81);

        // R2: unknown opcode does nothing
        wr(4'h7, 4'd0, 8'hEE);
        check("R2 unknown opcode", {24'h0, wiper}, 32'h77);

        // R7: wrong bit counts are discarded
        frame({16'h0, 4'h2, 4'd0, 8'h21} >> 1, 15, g);
        check("R7 15-bit window", {24'h0, wiper}, 32'h77);
        frame({15'h0, 1'b0, 4'h2, 4'd0, 8'h22}, 17, g);
        check("R7 17-bit window", {24'h0, wiper}, 32'h77);
        frame(32'h0, 0, g);
        check("R7 empty window", {24'h0, wiper}, 32'h77);

        // R8 R11: two chained words, the last 16 execute, input echoed
        frame({4'h2, 4'd0, 8'h99, 4'h2, 4'd0, 8'h12}, 32, g);
        check("R8 chain pass-through", {16'h0, g[15:0]}, {16'h0, 4'h2, 4'd0, 8'h99});
        check("R11 leading zeros", {16'h0, g[31:16]}, 32'h0);
        check("R8 last word executed", {24'h0, wiper}, 32'h12);

        // R11: a window not after a read returns zeros
        frame(32'h0, 16, g);
        check("R11 idle window zeros", {16'h0, g[15:0]}, 32'h0);

        // R6: read answered in a chained window; result ahead of echo
        frame({16'h0, 4'h1, 4'd7, 8'h00}, 16, g);
        frame(32'hABCD_0000, 32, g);
        check("R6 first word out", {16'h0, g[31:16]}, {16'h0, 4'h1, 4'd7, 8'hFF});
        check("R8 second word out", {16'h0, g[15:0]}, 32'hABCD);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule